// File: doc/BRIEF.md
# Direct-Map Window Address Translation Front End

This block is the first stage of a memory management unit. For every presented virtual address it decides in one registered step which of four routes applies. The address may pass straight through when direct addressing is selected. It may be remapped by one of four direct-map windows. It may be rejected as non-canonical. Otherwise it is handed to the page-table lookup path, which is a separate block. Each window is a configuration word that holds a per-privilege enable mask, a virtual segment tag and, for 32-bit operation, a physical segment that is substituted into the address.

The caller presents the address, the privilege level, the direct-address and paging mode bits, the four window words and a 64/32-bit mode select. One clock later the block returns a physical address, a read/write/execute permission triple, a result code, the index of the window that matched, and a request flag for the lookup path.

Top module: `dmw_xlate_front`

## Requirements
- R1: While reset is high, at the next clock edge the outputs become pa_o = 0, perm_o = 3'b000, res_o = 3 (bad), tlb_req_o = 0 and win_idx_o = 0.
- R2: When dam_i = 1 and pgen_i = 0, the result is res_o = 0 (direct), with pa_o equal to the low PA_W bits of the address and perm_o = 3'b111 ({exec, write, read}). The window words are ignored. Any other combination of the two bits goes on to the window check.
- R3: Privilege level 0 (kernel) enables a window through bit 0 of its word, and privilege level 3 (user) enables a window through bit 3. Levels 1 and 2 never enable a window.
- R4: In 64-bit mode (m64_i = 1), a window tag matches when bits [63:60] of the window word equal bits [63:60] of the address.
- R5: In 32-bit mode (m64_i = 0), a window tag matches when bits [31:29] of the window word equal bits [31:29] of the address.
- R6: Window 0 has the highest priority and window 3 the lowest. The lowest-indexed enabled, matching window wins, and its index is shown on win_idx_o. On a window hit res_o = 1 and perm_o = 3'b111. win_idx_o is 0 when no window hits.
- R7: A 64-bit window hit gives pa_o equal to the address masked to its low VA_W bits.
- R8: A 32-bit window hit gives pa_o = {zeros, word[27:25], address[28:0]}. This puts the window's physical segment in place of the address segment.
- R9: When no window hits and address bits [63:48] are all zeros or all ones, the result is res_o = 2 with tlb_req_o = 1, pa_o equal to the low PA_W address bits unchanged, and perm_o = 3'b000.
- R10: When no window hits and address bits [63:48] are mixed, the result is res_o = 3 with tlb_req_o = 0, pa_o = 0 and perm_o = 3'b000.
- R11: All outputs are registered and reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vaddr_i | input | ADDR_W | Virtual address |
| priv_i | input | 2 | Privilege level (0 kernel, 3 user) |
| dam_i | input | 1 | Direct-address mode bit |
| pgen_i | input | 1 | Paging enable bit |
| m64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| win_cfg_i | input | N_WIN*ADDR_W | Window words, window k at bits [k*ADDR_W +: ADDR_W] |
| pa_o | output | PA_W | Physical address |
| perm_o | output | 3 | {exec, write, read} grants |
| res_o | output | 2 | 0 direct, 1 window, 2 lookup request, 3 bad address |
| tlb_req_o | output | 1 | Request to the page-table lookup path |
| win_idx_o | output | IDX_W | Index of the winning window |

## Verification
Several functions can apply to the same address in one cycle. Direct addressing and a matching window can both apply, and so can two enabled windows with the same tag. The bench sets up both cases on purpose. It points the direct-mode address at a window whose tag matches. It loads windows 1 and 2 with identical tags and leaves window 0 non-matching. Randomized vectors draw address and tag nibbles from a small shared set, so overlaps happen often. A behavioural model resolves the order direct, then window 0 to 3, then the canonical check, and the result is compared on every cycle.

// File: rtl/dmw_pkg.sv
package dmw_pkg;
  typedef enum logic [1:0] {
    RES_DIRECT = 2'd0,
    RES_WINDOW = 2'd1,
    RES_TLB    = 2'd2,
    RES_BAD    = 2'd3
  } xres_e;

  localparam int KEN_BIT = 0;   // kernel enable bit inside a window word
  localparam int UEN_BIT = 3;   // user enable bit inside a window word
  localparam int EN_W    = 4;   // width of the enable nibble
  localparam logic [1:0] PRIV_KERN = 2'd0;
  localparam logic [1:0] PRIV_USER = 2'd3;
  localparam logic [2:0] PERM_ALL  = 3'b111;
endpackage

// File: rtl/dmw_window_match.sv
module dmw_window_match #(
  parameter int ADDR_W  = 64,
  parameter int SEG64_W = 4,
  parameter int SEG32_W = 3
) (
  input  logic [ADDR_W-1:0]       cfg_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [dmw_pkg::EN_W-1:0] priv_mask_i,
  input  logic                    m64_i,
  output logic                    hit_o
);
  localparam int W32 = 32;

  logic enabled, tag64, tag32;

  always_comb begin
    enabled = |(cfg_i[dmw_pkg::EN_W-1:0] & priv_mask_i);
    tag64   = (cfg_i[ADDR_W-1 -: SEG64_W] == addr_i[ADDR_W-1 -: SEG64_W]);
    tag32   = (cfg_i[W32-1 -: SEG32_W] == addr_i[W32-1 -: SEG32_W]);
    hit_o   = enabled && (m64_i ? tag64 : tag32);
  end
endmodule

// File: rtl/dmw_prio_pick.sv
module dmw_prio_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hits_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    // walk from the lowest priority so the last assignment is window 0
    for (int i = N - 1; i >= 0; i--) begin
      if (hits_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dmw_xlate_front.sv
module dmw_xlate_front #(
  parameter int ADDR_W  = 64,
  parameter int VA_W    = 48,
  parameter int PA_W    = 48,
  parameter int N_WIN   = 4,
  parameter int SEG64_W = 4,
  parameter int SEG32_W = 3,
  parameter int IDX_W   = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       vaddr_i,
  input  logic [1:0]              priv_i,
  input  logic                    dam_i,
  input  logic                    pgen_i,
  input  logic                    m64_i,
  input  logic [N_WIN*ADDR_W-1:0] win_cfg_i,
  output logic [PA_W-1:0]         pa_o,
  output logic [2:0]              perm_o,
  output logic [1:0]              res_o,
  output logic                    tlb_req_o,
  output logic [IDX_W-1:0]        win_idx_o
);
  import dmw_pkg::*;

  localparam int W32     = 32;
  localparam int LO32    = W32 - SEG32_W;      // address bits kept in 32-bit mode
  localparam int PSEG_HI = LO32 - 2;           // physical segment field top bit
  localparam int HI_W    = ADDR_W - VA_W;      // bits guarded by the canonical check
  localparam logic [ADDR_W-1:0] VA_MASK = {{HI_W{1'b0}}, {VA_W{1'b1}}};
  localparam logic [ADDR_W-1:0] PA_MASK = {{(ADDR_W-PA_W){1'b0}}, {PA_W{1'b1}}};

  logic [EN_W-1:0]   priv_mask;
  logic [N_WIN-1:0]  hits;
  logic              any_hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [ADDR_W-1:0] sel_cfg;
  logic [ADDR_W-1:0] pa_win64, pa_win32, pa_next;
  logic [HI_W-1:0]   upper;
  logic              canonical, direct;
  xres_e             res_next;
  logic [2:0]        perm_next;

  always_comb begin
    priv_mask = '0;
    priv_mask[KEN_BIT] = (priv_i == PRIV_KERN);
    priv_mask[UEN_BIT] = (priv_i == PRIV_USER);
  end

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    dmw_window_match #(
      .ADDR_W (ADDR_W),
      .SEG64_W(SEG64_W),
      .SEG32_W(SEG32_W)
    ) match_i (
      .cfg_i      (win_cfg_i[g*ADDR_W +: ADDR_W]),
      .addr_i     (vaddr_i),
      .priv_mask_i(priv_mask),
      .m64_i      (m64_i),
      .hit_o      (hits[g])
    );
  end

  dmw_prio_pick #(
    .N    (N_WIN),
    .IDX_W(IDX_W)
  ) pick_i (
    .hits_i(hits),
    .any_o (any_hit),
    .idx_o (hit_idx)
  );

  always_comb begin
    sel_cfg   = win_cfg_i[hit_idx*ADDR_W +: ADDR_W];
    pa_win64  = vaddr_i & VA_MASK;
    pa_win32  = {{(ADDR_W-W32){1'b0}}, sel_cfg[PSEG_HI -: SEG32_W], vaddr_i[LO32-1:0]};
    upper     = vaddr_i[ADDR_W-1:VA_W];
    canonical = (upper == '0) || (upper == '1);
    direct    = dam_i && !pgen_i;

    if (direct) begin
      res_next  = RES_DIRECT;
      pa_next   = vaddr_i & PA_MASK;
      perm_next = PERM_ALL;
    end else if (any_hit) begin
      res_next  = RES_WINDOW;
      pa_next   = m64_i ? pa_win64 : pa_win32;
      perm_next = PERM_ALL;
    end else if (canonical) begin
      res_next  = RES_TLB;
      pa_next   = vaddr_i & PA_MASK;
      perm_next = 3'b000;
    end else begin
      res_next  = RES_BAD;
      pa_next   = '0;
      perm_next = 3'b000;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_o      <= '0;
      perm_o    <= 3'b000;
      res_o     <= RES_BAD;
      tlb_req_o <= 1'b0;
      win_idx_o <= '0;
    end else begin
      pa_o      <= pa_next[PA_W-1:0];
      perm_o    <= perm_next;
      res_o     <= res_next;
      tlb_req_o <= (res_next == RES_TLB);
      win_idx_o <= (!direct && any_hit) ? hit_idx : '0;
    end
  end
endmodule

// File: rtl/dmw_xlate_front_chk.sv
module dmw_xlate_front_chk #(
  parameter int ADDR_W = 64,
  parameter int VA_W   = 48,
  parameter int PA_W   = 48,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] vaddr_i,
  input logic [1:0]        priv_i,
  input logic              dam_i,
  input logic              pgen_i,
  input logic [PA_W-1:0]   pa_o,
  input logic [2:0]        perm_o,
  input logic [1:0]        res_o,
  input logic              tlb_req_o,
  input logic [IDX_W-1:0]  win_idx_o
);
  localparam int HI_W = ADDR_W - VA_W;

  logic mixed_upper;
  assign mixed_upper = !((vaddr_i[ADDR_W-1:VA_W] == {HI_W{1'b0}}) ||
                         (vaddr_i[ADDR_W-1:VA_W] == {HI_W{1'b1}}));

  // R2: direct mode wins over everything on the next cycle
  assert_direct_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (dam_i && !pgen_i) |=> (res_o == 2'd0 && perm_o == 3'b111 &&
                            pa_o == $past(vaddr_i[PA_W-1:0])));

  // R3: privilege levels 1 and 2 never reach a window
  assert_mid_priv_no_window_R3: assert property (@(posedge clk) disable iff (rst)
    (!(dam_i && !pgen_i) && (priv_i == 2'd1 || priv_i == 2'd2)) |=> (res_o != 2'd1));

  // R6: a window result carries full permission
  assert_window_full_perm_R6: assert property (@(posedge clk) disable iff (rst)
    (res_o == 2'd1) |-> (perm_o == 3'b111));

  // R9: the lookup request accompanies only the lookup result
  assert_req_matches_code_R9: assert property (@(posedge clk) disable iff (rst)
    tlb_req_o == (res_o == 2'd2));

  // R10: a mixed upper field outside any window is rejected
  assert_bad_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (!(dam_i && !pgen_i) && (priv_i == 2'd1 || priv_i == 2'd2) && mixed_upper)
      |=> (res_o == 2'd3 && pa_o == '0 && perm_o == 3'b000 && !tlb_req_o));

  // R6: the window index is zero unless a window result is shown
  assert_idx_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (res_o != 2'd1) |-> (win_idx_o == '0));
endmodule

bind dmw_xlate_front dmw_xlate_front_chk #(
  .ADDR_W(ADDR_W),
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .IDX_W (IDX_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .vaddr_i  (vaddr_i),
  .priv_i   (priv_i),
  .dam_i    (dam_i),
  .pgen_i   (pgen_i),
  .pa_o     (pa_o),
  .perm_o   (perm_o),
  .res_o    (res_o),
  .tlb_req_o(tlb_req_o),
  .win_idx_o(win_idx_o)
);

// File: tb/dmw_xlate_front_tb_top.sv
`timescale 1ns/1ps
module dmw_xlate_front_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic [63:0]  vaddr_i;
  logic [1:0]   priv_i;
  logic         dam_i, pgen_i, m64_i;
  logic [255:0] win_cfg_i;
  logic [47:0]  pa_o;
  logic [2:0]   perm_o;
  logic [1:0]   res_o;
  logic         tlb_req_o;
  logic [1:0]   win_idx_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  dmw_xlate_front dut_i (
    .clk(clk), .rst(rst), .vaddr_i(vaddr_i), .priv_i(priv_i),
    .dam_i(dam_i), .pgen_i(pgen_i), .m64_i(m64_i), .win_cfg_i(win_cfg_i),
    .pa_o(pa_o), .perm_o(perm_o), .res_o(res_o), .tlb_req_o(tlb_req_o),
    .win_idx_o(win_idx_o)
  );

  // behavioural reference
  logic [47:0] e_pa;
  logic [2:0]  e_perm;
  logic [1:0]  e_res;
  logic        e_req;
  logic [1:0]  e_idx;

  task automatic model();
    logic [63:0] c;
    logic [3:0]  en;
    logic [15:0] top;
    bit found;
    en = (priv_i == 2'd0) ? 4'b0001 : (priv_i == 2'd3) ? 4'b1000 : 4'b0000;
    top = vaddr_i[63:48];
    found = 0;
    e_idx = 0; e_req = 0;
    if (dam_i && !pgen_i) begin
      e_res = 0; e_pa = vaddr_i[47:0]; e_perm = 3'b111;
    end else begin
      for (int w = 0; w < 4; w++) begin
        c = win_cfg_i[w*64 +: 64];
        if (!found && (c[3:0] & en) != 0 &&
            (m64_i ? (c[63:60] == vaddr_i[63:60]) : (c[31:29] == vaddr_i[31:29]))) begin
          found = 1;
          e_idx = 2'(w);
          e_res = 1; e_perm = 3'b111;
          if (m64_i) e_pa = vaddr_i[47:0];
          else e_pa = {16'h0, c[27:25], vaddr_i[28:0]};
        end
      end
      if (!found) begin
        if (top == 16'h0000 || top == 16'hFFFF) begin
          e_res = 2; e_req = 1; e_pa = vaddr_i[47:0]; e_perm = 3'b000;
        end else begin
          e_res = 3; e_pa = 48'h0; e_perm = 3'b000;
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (pa_o !== e_pa || perm_o !== e_perm || res_o !== e_res ||
        tlb_req_o !== e_req || win_idx_o !== e_idx) begin
      miscompares++;
      $display("FAIL %s: got pa=%h perm=%b res=%0d req=%b idx=%0d exp pa=%h perm=%b res=%0d req=%b idx=%0d",
               tag, pa_o, perm_o, res_o, tlb_req_o, win_idx_o,
               e_pa, e_perm, e_res, e_req, e_idx);
    end
  endtask

  // drive at a falling edge, compare at the next falling edge (one register, R11)
  task automatic apply(input string tag, input logic [63:0] a, input logic [1:0] p,
                       input logic da, input logic pg, input logic m64);
    vaddr_i = a; priv_i = p; dam_i = da; pgen_i = pg; m64_i = m64;
    model();
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [63:0] pick_nib_addr(input int r);
    logic [3:0] n;
    case (r % 4)
      0: n = 4'h0; 1: n = 4'hF; 2: n = 4'h9; default: n = 4'hA;
    endcase
    return {n, 60'h0};
  endfunction

  initial begin
    rst = 1; vaddr_i = 0; priv_i = 0; dam_i = 0; pgen_i = 1; m64_i = 1; win_cfg_i = '0;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    e_pa = 0; e_perm = 0; e_res = 3; e_req = 0; e_idx = 0;
    compare("R1 reset");
    @(negedge clk);
    rst = 0;

    // windows: 0 tag 9 kernel only, 1 and 2 tag A user, 3 tag 5 user
    win_cfg_i[0*64 +: 64] = 64'h9000_0000_0000_0001;
    win_cfg_i[1*64 +: 64] = 64'hA000_0000_0000_0008;
    win_cfg_i[2*64 +: 64] = 64'hA000_0000_A600_0008;
    win_cfg_i[3*64 +: 64] = 64'h5000_0000_0000_0009;

    apply("R2 direct overrides matching window", 64'h9000_1234_5678_9ABC, 2'd0, 1, 0, 1);
    apply("R2 direct with high ones", 64'hFFFF_1234_5678_9ABC, 2'd3, 1, 0, 1);
    apply("R3 R4 R7 kernel hit win0", 64'h9000_0000_0000_1000, 2'd0, 0, 1, 1);
    apply("R3 user blocked on kernel-only window", 64'h9000_0000_0000_1000, 2'd3, 0, 1, 1);
    apply("R3 level 1 never enables", 64'h5000_0000_0000_0040, 2'd1, 0, 1, 1);
    apply("R3 level 2 canonical to lookup", 64'h0000_0000_0000_0040, 2'd2, 0, 1, 1);
    apply("R6 tie picks window 1", 64'hA000_0000_0000_0ABC, 2'd3, 0, 1, 1);
    apply("R2 both mode bits set goes to windows", 64'hA000_0000_0000_0ABC, 2'd3, 1, 1, 1);
    apply("R4 kernel hit on win3", 64'h5000_0000_1111_2222, 2'd0, 0, 0, 1);
    apply("R5 R8 32-bit hit win2", 64'h0000_0000_A123_4567, 2'd3, 0, 1, 0);
    apply("R9 high ones to lookup", 64'hFFFF_8000_0000_0000, 2'd0, 0, 1, 1);
    apply("R9 32-bit miss to lookup", 64'h0000_0000_2000_0010, 2'd0, 0, 1, 0);
    apply("R10 mixed upper rejected", 64'h0001_0000_0000_0000, 2'd0, 0, 1, 1);
    apply("R10 32-bit mixed upper rejected", 64'h1234_0000_2000_0000, 2'd3, 0, 1, 0);

    // randomized overlap-heavy vectors
    for (int k = 0; k < 800; k++) begin
      logic [63:0] a;
      for (int w = 0; w < 4; w++)
        win_cfg_i[w*64 +: 64] = pick_nib_addr($urandom) |
          {32'h0, $urandom} & 64'h0000_0000_FFFF_FFFF | {63'h0, 1'b0};
      a = pick_nib_addr($urandom) | {$urandom & 32'h0000_FFFF, $urandom};
      if ($urandom % 3 == 0) a[63:48] = {16{a[47]}};
      apply("R11 random", a, 2'($urandom), ($urandom % 5 == 0), 1'($urandom), 1'($urandom));
    end

    // R1: reset in the middle of traffic
    rst = 1;
    @(negedge clk);
    e_pa = 0; e_perm = 0; e_res = 3; e_req = 0; e_idx = 0;
    compare("R1 mid-run reset");
    rst = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule